// File: doc/BRIEF.md
# Source-Routed Crossbar Stage with Route-Flit Removal

This block is one switching element of a multistage interconnect that is routed entirely by the sender. Packets travel as flit streams on valid/ready ports, and a marker flags the final flit of each packet. The stage reads the leading flit of every packet arriving on an input. The low bits of that flit name the output port, and the flit is then discarded. The remaining flits follow over a connection that stays in place until the final flit has gone through. When several inputs want the same output, a rotating-priority arbiter picks one. The inputs that lose simply wait, and no flit is lost.

A companion header builder sits at the packet source. It takes a destination number and cuts it into groups of log2(radix) bits, one group per stage. It emits these groups as leading flits, the highest group first, so the first stage is steered by the top bits of the destination. It then passes the payload through unchanged. Each stage strips one such flit, so a packet that has crossed every stage carries data only. A packet with no payload still ends with a tail indication: its last route flit carries the end marker, and the stage that consumes it sends out a single zero flit marked as the end.

Top module: `srt_stage`

## Requirements
- R1: While reset is held and in the first cycle after it, every out_valid is 0 and every in_ready is 1.
- R2: For each packet arriving on an input, bits [log2(RADIX)-1:0] of its first flit choose the output port, the other bits of that flit are ignored, and that flit never appears on any output.
- R3: The flits after the first leave on the chosen output in arrival order with unchanged data, and out_last is asserted exactly on the packet's final flit.
- R4: Once an output is granted to an input, it carries only that input's flits until the flit marked last has been accepted, and then it is free for another packet.
- R5: Contention for an output is settled round-robin. After reset, input 0 has the highest priority. After a grant to input i, the search for that output's next grant starts at input i+1, wrapping around.
- R6: While out_ready is low, out_valid, out_data and out_last hold their values, and the input stops accepting once its one-flit slot is full, so no flit is lost or repeated.
- R7: A packet made only of a route flit (its first flit is already marked last) produces exactly one flit on the chosen output, with all-zero data and out_last set.
- R8: Packets from different inputs to different outputs move in the same cycles, and no output is ever connected to two inputs at once.
- R9: For a destination D, the header builder first emits STAGES route flits. Flit k (k = 0 first) carries (D >> (log2(RADIX)*(STAGES-1-k))) & (RADIX-1) in its low bits, and the upper bits are zero.
- R10: After the route flits, the header builder passes the payload flits through unchanged, with their end marker. For a packet flagged as having no payload, the last route flit carries the end marker and the accompanying source flit is consumed without being forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | RADIX | Flit offered on each input |
| in_data | input | RADIX*W | Flit payload, input p in bits [p*W +: W] |
| in_last | input | RADIX | Offered flit ends its packet |
| in_ready | output | RADIX | Input can take a flit this cycle |
| out_valid | output | RADIX | Flit presented on each output |
| out_data | output | RADIX*W | Output flit payload, output o in bits [o*W +: W] |
| out_last | output | RADIX | Presented flit ends its packet |
| out_ready | input | RADIX | Downstream takes the presented flit |

## Verification
Suppose an input's phase or an output's lock goes wrong. The first packet that crosses the bad path then shows it, as soon as its end marker arrives: it comes out on the wrong port, has the wrong length, carries flits from another source mixed in, or hangs until the watchdog expires. A fault in the arbiter pointer stays hidden until two route flits reach the same output in the same cycle. The directed contention pairs are there to make that happen. A bad digit slice in the header builder shows in the first flits of the very next packet.

// File: rtl/srt_pkg.sv
package srt_pkg;

   typedef enum logic [1:0] {
      PH_HEAD = 2'd0,
      PH_WAIT = 2'd1,
      PH_PASS = 2'd2
   } in_phase_e;

   // Digit steering stage k (k = 0 is the first stage the packet meets).
   function automatic logic [31:0] route_digit(input logic [31:0] dest,
                                               input int unsigned lg,
                                               input int unsigned nst,
                                               input int unsigned k);
      logic [31:0] shifted;
      shifted = dest >> (lg * (nst - 1 - k));
      return shifted & ((32'd1 << lg) - 32'd1);
   endfunction

endpackage

// File: rtl/srt_in_slot.sv
module srt_in_slot #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic         in_last,
   output logic         in_ready,
   input  logic         pop,
   output logic         slot_v,
   output logic [W-1:0] slot_data,
   output logic         slot_last
);

   assign in_ready = !slot_v || pop;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_v    <= 1'b0;
         slot_data <= '0;
         slot_last <= 1'b0;
      end else if (in_valid && in_ready) begin
         slot_v    <= 1'b1;
         slot_data <= in_data;
         slot_last <= in_last;
      end else if (pop) begin
         slot_v    <= 1'b0;
      end
   end

endmodule

// File: rtl/srt_rr_arb.sv
module srt_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if ((1 << IW) != N) begin : g_bad_n
      $error("srt_rr_arb: N must be a power of two");
   end

   logic [IW-1:0] ptr;
   logic [IW-1:0] win;
   logic [IW-1:0] cand;
   logic          hit;

   always_comb begin
      grant = '0;
      hit   = 1'b0;
      win   = '0;
      cand  = '0;
      for (int k = 0; k < N; k++) begin
         cand = ptr + IW'(k);
         if (!hit && req[cand]) begin
            hit = 1'b1;
            win = cand;
         end
      end
      if (en && hit) grant[win] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)            ptr <= '0;
      else if (en && hit) ptr <= win + IW'(1);
   end

endmodule

// File: rtl/srt_route_gen.sv
module srt_route_gen #(
   parameter int RADIX  = 4,
   parameter int STAGES = 3,
   parameter int W      = 16
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             src_valid,
   input  logic [STAGES*$clog2(RADIX)-1:0]  src_dest,
   input  logic                             src_empty,
   input  logic [W-1:0]                     src_data,
   input  logic                             src_last,
   output logic                             src_ready,
   output logic                             rt_valid,
   output logic [W-1:0]                     rt_data,
   output logic                             rt_last,
   input  logic                             rt_ready
);

   import srt_pkg::*;

   localparam int LG = $clog2(RADIX);
   localparam int DW = STAGES * LG;
   localparam int CW = (STAGES > 1) ? $clog2(STAGES) : 1;

   if (RADIX != 2 && RADIX != 4) begin : g_bad_radix
      $error("srt_route_gen: RADIX must be 2 or 4");
   end
   if (W < LG || DW > 32 || STAGES < 1) begin : g_bad_width
      $error("srt_route_gen: width or stage count out of range");
   end

   logic          data_ph;
   logic [CW-1:0] cnt;
   logic          at_end;
   logic [31:0]   digit;

   assign at_end = (cnt == CW'(STAGES - 1));
   assign digit  = route_digit(32'(src_dest), LG, STAGES, 32'(cnt));

   always_comb begin
      rt_valid = src_valid;
      if (data_ph) begin
         rt_data   = src_data;
         rt_last   = src_last;
         src_ready = rt_ready;
      end else begin
         rt_data   = W'(digit);
         rt_last   = src_empty && at_end;
         src_ready = rt_ready && src_empty && at_end;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_ph <= 1'b0;
         cnt     <= '0;
      end else if (rt_valid && rt_ready) begin
         if (data_ph) begin
            if (src_last) data_ph <= 1'b0;
         end else if (at_end) begin
            cnt <= '0;
            if (!src_empty) data_ph <= 1'b1;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/srt_stage.sv
module srt_stage #(
   parameter int RADIX = 4,
   parameter int W     = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [RADIX-1:0]   in_valid,
   input  logic [RADIX*W-1:0] in_data,
   input  logic [RADIX-1:0]   in_last,
   output logic [RADIX-1:0]   in_ready,
   output logic [RADIX-1:0]   out_valid,
   output logic [RADIX*W-1:0] out_data,
   output logic [RADIX-1:0]   out_last,
   input  logic [RADIX-1:0]   out_ready
);

   import srt_pkg::*;

   localparam int LG = $clog2(RADIX);

   if (RADIX != 2 && RADIX != 4) begin : g_bad_radix
      $error("srt_stage: RADIX must be 2 or 4");
   end
   if (W < LG) begin : g_bad_width
      $error("srt_stage: W must hold a route digit");
   end

   logic [RADIX-1:0]    slot_v;
   logic [RADIX-1:0]    slot_l;
   logic [RADIX-1:0]    pop;
   logic [RADIX-1:0]    hs;
   logic [RADIX-1:0]    emp;
   logic [RADIX-1:0]    won;
   logic [W-1:0]        slot_d [RADIX];
   logic [W-1:0]        fwd_d  [RADIX];
   in_phase_e           ph     [RADIX];
   logic [LG-1:0]       dst    [RADIX];
   logic [RADIX-1:0]    req    [RADIX];
   logic [RADIX-1:0]    gnt    [RADIX];
   logic [RADIX-1:0]    own_busy;
   logic [RADIX*LG-1:0] own_idx;

   // Input side: one slot and a phase tracker per input.
   for (genvar i = 0; i < RADIX; i++) begin : g_in
      in_phase_e     ph_q;
      logic [LG-1:0] dst_q;
      logic          emp_q;

      srt_in_slot #(.W(W)) u_slot (
         .clk       (clk),
         .rst       (rst),
         .in_valid  (in_valid[i]),
         .in_data   (in_data[i*W +: W]),
         .in_last   (in_last[i]),
         .in_ready  (in_ready[i]),
         .pop       (pop[i]),
         .slot_v    (slot_v[i]),
         .slot_data (slot_d[i]),
         .slot_last (slot_l[i])
      );

      assign ph[i]    = ph_q;
      assign dst[i]   = dst_q;
      assign emp[i]   = emp_q;
      assign hs[i]    = (ph_q == PH_PASS) && slot_v[i] && out_ready[dst_q];
      assign pop[i]   = ((ph_q == PH_HEAD) && slot_v[i] && !slot_l[i]) || hs[i];
      assign fwd_d[i] = emp_q ? '0 : slot_d[i];

      always_ff @(posedge clk) begin
         if (rst) begin
            ph_q  <= PH_HEAD;
            dst_q <= '0;
            emp_q <= 1'b0;
         end else begin
            case (ph_q)
               PH_HEAD: if (slot_v[i]) begin
                  dst_q <= slot_d[i][LG-1:0];
                  emp_q <= slot_l[i];
                  ph_q  <= PH_WAIT;
               end
               PH_WAIT: if (won[i]) ph_q <= PH_PASS;
               PH_PASS: if (hs[i] && slot_l[i]) begin
                  ph_q  <= PH_HEAD;
                  emp_q <= 1'b0;
               end
               default: ph_q <= PH_HEAD;
            endcase
         end
      end
   end

   always_comb begin
      for (int o = 0; o < RADIX; o++) begin
         for (int i = 0; i < RADIX; i++) begin
            req[o][i] = (ph[i] == PH_WAIT) && (dst[i] == LG'(o));
         end
      end
   end

   always_comb begin
      won = '0;
      for (int o = 0; o < RADIX; o++) won = won | gnt[o];
   end

   // Output side: arbiter plus a lock that holds until the tail passes.
   for (genvar o = 0; o < RADIX; o++) begin : g_out
      logic          busy_q;
      logic [LG-1:0] own_q;
      logic [LG-1:0] gidx;

      srt_rr_arb #(.N(RADIX)) u_arb (
         .clk   (clk),
         .rst   (rst),
         .en    (!busy_q),
         .req   (req[o]),
         .grant (gnt[o])
      );

      always_comb begin
         gidx = '0;
         for (int i = 0; i < RADIX; i++) begin
            if (gnt[o][i]) gidx = LG'(i);
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            busy_q <= 1'b0;
            own_q  <= '0;
         end else if (!busy_q && (|gnt[o])) begin
            busy_q <= 1'b1;
            own_q  <= gidx;
         end else if (busy_q && out_valid[o] && out_ready[o] && out_last[o]) begin
            busy_q <= 1'b0;
         end
      end

      assign own_busy[o]             = busy_q;
      assign own_idx[o*LG +: LG]     = own_q;
      assign out_valid[o]            = busy_q && slot_v[own_q];
      assign out_data[o*W +: W]      = fwd_d[own_q];
      assign out_last[o]             = slot_l[own_q];
   end

endmodule

// File: rtl/srt_stage_chk.sv
module srt_stage_chk #(
   parameter int RADIX = 4,
   parameter int W     = 16,
   parameter int LG    = $clog2(RADIX)
) (
   input logic               clk,
   input logic               rst,
   input logic [RADIX-1:0]   in_ready,
   input logic [RADIX-1:0]   out_valid,
   input logic [RADIX*W-1:0] out_data,
   input logic [RADIX-1:0]   out_last,
   input logic [RADIX-1:0]   out_ready,
   input logic [RADIX-1:0]   own_busy,
   input logic [RADIX*LG-1:0] own_idx
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |=> (out_valid == '0));

   // R1
   reset_ready_chk: assert property (@(posedge clk) rst |=> (in_ready == '1));

   for (genvar o = 0; o < RADIX; o++) begin : g_o
      // R6
      stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
         (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o*W +: W]) && $stable(out_last[o])));

      // R4
      tail_release_chk: assert property (@(posedge clk) disable iff (rst)
         (out_valid[o] && out_ready[o] && out_last[o]) |=> !own_busy[o]);

      // R4
      owner_steady_chk: assert property (@(posedge clk) disable iff (rst)
         (own_busy[o] && $past(own_busy[o]) && !$past(rst)) |->
            $stable(own_idx[o*LG +: LG]));

      for (genvar p = o + 1; p < RADIX; p++) begin : g_p
         // R8
         one_owner_chk: assert property (@(posedge clk) disable iff (rst)
            (own_busy[o] && own_busy[p]) |->
               (own_idx[o*LG +: LG] != own_idx[p*LG +: LG]));
      end
   end

endmodule

bind srt_stage srt_stage_chk #(.RADIX(RADIX), .W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_last  (out_last),
   .out_ready (out_ready),
   .own_busy  (own_busy),
   .own_idx   (own_idx)
);

// File: tb/srt_stage_bench.sv
`timescale 1ns/1ps
module srt_stage_bench;

   localparam int RADIX  = 4;
   localparam int W      = 16;
   localparam int STAGES = 3;
   localparam int LG     = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [RADIX-1:0]   in_valid, in_last, in_ready;
   logic [RADIX-1:0]   out_valid, out_last, out_ready;
   logic [RADIX*W-1:0] in_data, out_data;

   logic         iv [RADIX];
   logic [W-1:0] id [RADIX];
   logic         il [RADIX];

   always_comb begin
      for (int p = 0; p < RADIX; p++) begin
         in_valid[p]        = iv[p];
         in_data[p*W +: W]  = id[p];
         in_last[p]         = il[p];
      end
   end

   srt_stage #(.RADIX(RADIX), .W(W)) u_srt_stage (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
   );

   logic                 g_sv, g_se, g_sl, g_sr, g_rv, g_rl, g_rr;
   logic [STAGES*LG-1:0] g_dest;
   logic [W-1:0]         g_sd, g_rd;

   srt_route_gen #(.RADIX(RADIX), .STAGES(STAGES), .W(W)) u_gen (
      .clk(clk), .rst(rst),
      .src_valid(g_sv), .src_dest(g_dest), .src_empty(g_se), .src_data(g_sd),
      .src_last(g_sl), .src_ready(g_sr),
      .rt_valid(g_rv), .rt_data(g_rd), .rt_last(g_rl), .rt_ready(g_rr)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // Scoreboard state
   int exp_dst [RADIX][64];
   int exp_len [RADIX][64];
   int pid_ctr [RADIX];
   int sent_n = 0;
   int got_n  = 0;
   int empty_cnt [RADIX];
   bit inpkt [RADIX];
   int cs [RADIX];
   int cp [RADIX];
   int cn [RADIX];
   bit cbad [RADIX];
   int o0_log [64];
   int log_n = 0;
   bit both01 = 1'b0;
   int rdy_mode = 0;

   task automatic take_flit(input int o, input logic [W-1:0] d, input logic l);
      if (!inpkt[o]) begin
         if (d == '0) begin
            if (l) empty_cnt[o]++;
            else chk(1'b0, "R7 stray zero flit", o, -1);
            return;
         end
         inpkt[o] = 1'b1;
         cs[o]    = int'(d[15:14]);
         cp[o]    = int'(d[13:8]);
         cn[o]    = 0;
         cbad[o]  = 1'b0;
      end
      cn[o]++;
      if (int'(d[15:14]) != cs[o] || int'(d[13:8]) != cp[o] || int'(d[7:0]) != cn[o])
         cbad[o] = 1'b1;
      if (l) begin
         inpkt[o] = 1'b0;
         chk(!cbad[o], "R4 packet stays contiguous and ordered", int'(cbad[o]), 0);
         chk(o == exp_dst[cs[o]][cp[o]], "R2 output chosen by route flit", o, exp_dst[cs[o]][cp[o]]);
         chk(cn[o] == exp_len[cs[o]][cp[o]], "R3 payload length and last marker", cn[o], exp_len[cs[o]][cp[o]]);
         got_n++;
         if (o == 0 && log_n < 64) begin
            o0_log[log_n] = cs[o];
            log_n++;
         end
      end
   endtask

   // Output side: drive ready away from the edge, sample just before it.
   always begin
      @(negedge clk);
      for (int o = 0; o < RADIX; o++) begin
         out_ready[o] = (rdy_mode == 0) ? 1'b1 :
                        (rdy_mode == 1) ? 1'($urandom % 2) : 1'b0;
      end
      #4;
      if (!rst) begin
         if (out_valid[0] && out_valid[1]) both01 = 1'b1;
         for (int o = 0; o < RADIX; o++) begin
            if (out_valid[o] && out_ready[o]) take_flit(o, out_data[o*W +: W], out_last[o]);
         end
      end
   end

   task automatic send_pkt(input int p, input int dst, input int n);
      int pid;
      pid = pid_ctr[p];
      pid_ctr[p]++;
      exp_dst[p][pid] = dst;
      exp_len[p][pid] = n;
      if (n > 0) sent_n++;
      for (int k = 0; k <= n; k++) begin
         @(negedge clk);
         iv[p] = 1'b1;
         if (k == 0) id[p] = W'(($urandom & 32'hFFFC) | 32'(dst));
         else        id[p] = {2'(p), 6'(pid), 8'(k)};
         il[p] = (k == n);
         #4;
         while (!in_ready[p]) begin
            @(negedge clk);
            #4;
         end
      end
      @(negedge clk);
      iv[p] = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      for (int p = 0; p < RADIX; p++) begin
         iv[p] = 1'b0; id[p] = '0; il[p] = 1'b0; inpkt[p] = 1'b0;
      end
      g_sv = 1'b0; g_se = 1'b0; g_sl = 1'b0; g_sd = '0; g_dest = '0; g_rr = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      log_n = 0;
   endtask

   task automatic drain();
      int t;
      t = 0;
      while (got_n != sent_n && t < 5000) begin
         @(negedge clk);
         t++;
      end
      repeat (6) @(negedge clk);
      chk(got_n == sent_n, "R3 every sent packet delivered", got_n, sent_n);
   endtask

   task automatic rand_src(input int p);
      for (int j = 0; j < 25; j++) begin
         repeat ($urandom % 3) @(negedge clk);
         send_pkt(p, int'($urandom % RADIX), 1 + int'($urandom % 6));
      end
   endtask

   function automatic int gdig(input int dest, input int k);
      return (dest >> (LG * (STAGES - 1 - k))) & (RADIX - 1);
   endfunction

   // Header builder: n payload flits, n == 0 means route-only.
   task automatic gen_pkt(input int dest, input int n);
      int nsrc, nout, si, oc, miss_rt, miss_dt;
      nsrc = (n == 0) ? 1 : n;
      nout = STAGES + n;
      si = 0; oc = 0; miss_rt = 0; miss_dt = 0;
      while (oc < nout) begin
         @(negedge clk);
         g_sv   = (si < nsrc);
         g_dest = (STAGES*LG)'(dest);
         g_se   = (n == 0);
         g_sd   = W'(32'hA000 + 32'(si + 1));
         g_sl   = (n > 0) && (si == n - 1);
         g_rr   = 1'($urandom % 4 != 0);
         #4;
         if (g_rv && g_rr) begin
            if (oc < STAGES) begin
               if (g_rd != W'(gdig(dest, oc))) miss_rt++;
               if (g_rl != ((n == 0) && (oc == STAGES - 1))) miss_dt++;
            end else begin
               if (g_rd != W'(32'hA000 + 32'(oc - STAGES + 1))) miss_dt++;
               if (g_rl != (oc == nout - 1)) miss_dt++;
            end
            oc++;
         end
         if (g_sv && g_sr) si++;
      end
      @(negedge clk);
      g_sv = 1'b0;
      chk(miss_rt == 0, "R9 route digits, top group first", miss_rt, 0);
      chk(miss_dt == 0 && si == nsrc, "R10 payload pass-through and end marker", miss_dt, 0);
   endtask

   initial begin
      #1_500_000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int p = 0; p < RADIX; p++) begin
         pid_ctr[p] = 0; empty_cnt[p] = 0;
      end
      out_ready = '1;
      do_reset();

      // R1 reset state
      #4;
      chk(out_valid == '0, "R1 outputs idle after reset", int'(out_valid), 0);
      chk(in_ready == '1, "R1 inputs ready after reset", int'(in_ready), 15);

      // R2 R3 single packets on distinct paths
      send_pkt(0, 3, 4);
      send_pkt(2, 1, 1);
      drain();

      // R7 route-only packet
      send_pkt(1, 2, 0);
      repeat (10) @(negedge clk);
      chk(empty_cnt[2] == 1, "R7 route-only packet gives one zero tail flit", empty_cnt[2], 1);
      send_pkt(3, 2, 2);
      send_pkt(3, 2, 0);
      drain();
      chk(empty_cnt[2] == 2, "R7 route-only after a data packet", empty_cnt[2], 2);

      // R5 round-robin from a known pointer
      do_reset();
      send_pkt(2, 0, 1);
      drain();
      fork
         send_pkt(0, 0, 2);
         send_pkt(3, 0, 2);
      join
      drain();
      fork
         send_pkt(0, 0, 1);
         send_pkt(3, 0, 3);
      join
      drain();
      chk(o0_log[1] == 3, "R5 pointer after input 2 favours input 3", o0_log[1], 3);
      chk(o0_log[2] == 0, "R5 losing input served next", o0_log[2], 0);
      chk(o0_log[3] == 3, "R5 rotation continues past input 0", o0_log[3], 3);
      chk(o0_log[4] == 0, "R5 second contention order", o0_log[4], 0);

      // R8 crossing paths in parallel
      both01 = 1'b0;
      fork
         send_pkt(0, 1, 6);
         send_pkt(1, 0, 6);
      join
      drain();
      chk(both01, "R8 disjoint outputs active together", int'(both01), 1);

      // R6 stall: output blocked, input fills and stops
      fork
         send_pkt(0, 3, 3);
         begin
            rdy_mode = 2;
            repeat (20) @(negedge clk);
            #4;
            chk(out_valid[3] == 1'b1, "R6 flit held on stalled output", int'(out_valid[3]), 1);
            chk(in_ready[0] == 1'b0, "R6 input stops when slot full", int'(in_ready[0]), 0);
            @(negedge clk);
            rdy_mode = 0;
         end
      join
      drain();

      // Random traffic with random backpressure (R2 R3 R4 R6)
      rdy_mode = 1;
      fork
         rand_src(0);
         rand_src(1);
         rand_src(2);
         rand_src(3);
      join
      rdy_mode = 0;
      drain();

      // Header builder (R9 R10)
      gen_pkt(6'b11_01_10, 2);
      gen_pkt(6'b00_11_01, 0);
      for (int j = 0; j < 6; j++) gen_pkt(int'($urandom % 64), int'($urandom % 4));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule